// File: doc/BRIEF.md
# JTAG Debug-Port Test Access Port

This block is the scan-side front end of a debug port. A debugger drives TCK, TMS, TDI and an active-low TRST; the block runs the sixteen-state IEEE 1149.1 controller, holds a 4-bit instruction register, and steers TDO from one of three data paths: a one-bit bypass stage, a fixed 32-bit identification value, or a 35-bit access register that carries a request towards the debug-port registers.

An access scan works in two phases. It shifts in a request made of write data, a 2-bit register address and a read/write flag. At Update-DR that request leaves the block as a one-cycle pulse on a simple request bus. The logic behind the bus answers with a response pulse that carries read data and a 3-bit acknowledge. The next access scan captures that answer and shifts it out. If the previous request has not been answered by the time the next access scan captures, that scan returns WAIT and its own request is discarded. The whole block runs in the TCK domain, and the response inputs must be synchronous to TCK.

The controller states are Test-Logic-Reset, Run-Test/Idle, Select-DR-Scan, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR, Update-DR, and the matching Select/Capture/Shift/Exit1/Pause/Exit2/Update states on the IR side. On TMS the transitions are as follows:
- Test-Logic-Reset goes to itself on 1 and to Run-Test/Idle on 0.
- Run-Test/Idle goes to Select-DR on 1 and to itself on 0.
- Select-DR goes to Select-IR on 1 and to Capture-DR on 0.
- Select-IR goes to Test-Logic-Reset on 1 and to Capture-IR on 0.
- Capture goes to Exit1 on 1 and to Shift on 0.
- Shift goes to Exit1 on 1 and to itself on 0.
- Exit1 goes to Update on 1 and to Pause on 0.
- Pause goes to Exit2 on 1 and to itself on 0.
- Exit2 goes to Update on 1 and back to Shift on 0.
- Update goes to Select-DR on 1 and to Run-Test/Idle on 0.

Top module: `dbg_tap`

## Requirements
- R1: TRST low (asynchronously) or five consecutive TCK rising edges with TMS high put the controller in Test-Logic-Reset. Entering or staying in Test-Logic-Reset loads the instruction register with the identification code 4'b1110.
- R2: The controller follows the standard sixteen-state transition graph listed above, including the Pause/Exit2 loop back into Shift, without losing shifted data.
- R3: Capture-IR loads the instruction shift stage with 4'b0001. Shift-IR moves bits LSB first from TDI towards TDO. Update-IR copies the shift stage into the active instruction.
- R4: Instruction 4'b1110 selects a 32-bit register that captures 32'h0BA00477 and shifts it out LSB first.
- R5: Instruction 4'b1111 selects a one-bit bypass stage that captures 0, so TDO repeats TDI delayed by one shift.
- R6: Any instruction code other than 4'b1110, 4'b1111 and 4'b1010 behaves exactly as bypass.
- R7: Instruction 4'b1010 selects a 35-bit access register. The shifted-in bit 0 is the read flag (1 = read), bits 2:1 are the register address, and bits 34:3 are the write data. Update-DR then raises req_valid for exactly one TCK cycle with those fields.
- R8: Capture-DR on the access register loads bits 34:3 with the most recently returned read data and bits 2:0 with its acknowledge (3'b010 OK, 3'b001 WAIT). After TRST these hold 0 and 3'b010.
- R9: While a request is outstanding (issued and not yet answered by rsp_valid), an access capture loads acknowledge 3'b001 and the following Update-DR issues no request. A rsp_valid with no outstanding request is ignored.
- R10: TDO changes only on the falling edge of TCK, presents bit 0 of the active shift stage during Shift-IR/Shift-DR, and is 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on TCK rise |
| tdi | input | 1 | Serial data in, sampled on TCK rise |
| tdo | output | 1 | Serial data out, updated on TCK fall |
| req_valid | output | 1 | One-cycle request pulse |
| req_addr | output | 2 | Debug-port register address bits |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_wdata | output | 32 | Write data of the request |
| rsp_valid | input | 1 | Response pulse for the outstanding request |
| rsp_rdata | input | 32 | Returned read data |
| rsp_ack | input | 3 | Returned acknowledge code |

## Verification
The checker watches the controller on every TCK edge. It confirms that five TMS-high edges always land in Test-Logic-Reset, that Test-Logic-Reset always leaves the identification instruction behind, and that a request pulse lasts one cycle, follows Update-DR and only appears under the access instruction. Only the bench's scan sequences can show the serial contents: the captured identification value, the bypass delay, the access-register layout in both directions, WAIT when a request is outstanding with its request dropped, the Pause/Exit2 round trip and the falling-edge timing of TDO. The bench checks these against a model of the outstanding-request state under random request and response traffic.

// File: rtl/dbg_tap_pkg.sv
package dbg_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_ACC
    } dr_path_t;

    localparam int          OP_W      = 4;
    localparam logic [3:0]  OP_BYPASS = 4'b1111;
    localparam logic [3:0]  OP_IDENT  = 4'b1110;
    localparam logic [3:0]  OP_ACCESS = 4'b1010;
    localparam logic [3:0]  IR_CAP    = 4'b0001;

    localparam logic [2:0]  ACK_OK    = 3'b010;
    localparam logic [2:0]  ACK_WAIT  = 3'b001;

endpackage

// File: rtl/dbg_tap_fsm.sv
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       up_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       up_ir
);

    tap_state_t nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UP_DR  : ST_PA_DR;
            ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: nxt = tms ? ST_UP_DR  : ST_SH_DR;
            ST_UP_DR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UP_IR  : ST_PA_IR;
            ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: nxt = tms ? ST_UP_IR  : ST_SH_IR;
            ST_UP_IR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
        endcase
    end

    always_comb begin
        in_reset = (state == ST_RESET);
        cap_dr   = (state == ST_CAP_DR);
        sh_dr    = (state == ST_SH_DR);
        up_dr    = (state == ST_UP_DR);
        cap_ir   = (state == ST_CAP_IR);
        sh_ir    = (state == ST_SH_IR);
        up_ir    = (state == ST_UP_IR);
    end

endmodule

// File: rtl/dbg_tap_ir.sv
module dbg_tap_ir
    import dbg_tap_pkg::*;
#(
    parameter int          W        = OP_W,
    parameter logic [W-1:0] RST_OP  = OP_IDENT,
    parameter logic [W-1:0] CAP_PAT = IR_CAP
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  logic         in_reset,
    input  logic         cap,
    input  logic         sh,
    input  logic         up,
    output logic [W-1:0] op,
    output logic         lsb
);

    logic [W-1:0] stage;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            stage <= CAP_PAT;
            op    <= RST_OP;
        end else begin
            if (cap)     stage <= CAP_PAT;
            else if (sh) stage <= {tdi, stage[W-1:1]};
            if (in_reset) op <= RST_OP;
            else if (up)  op <= stage;
        end
    end

    assign lsb = stage[0];

endmodule

// File: rtl/dbg_tap_dr.sv
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          AW     = 2,
    parameter int          KW     = 3,
    parameter logic [31:0] ID_VAL = 32'h0BA00477
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic          tdi,
    input  logic [OP_W-1:0] op,
    input  logic          cap,
    input  logic          sh,
    input  logic          up,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_rdata,
    input  logic [KW-1:0] rsp_ack,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          req_rnw,
    output logic [DW-1:0] req_wdata,
    output logic          lsb
);

    localparam int ACC_W = DW + KW;
    localparam int ID_W  = 32;
    localparam int SR_W  = (ACC_W > ID_W) ? ACC_W : ID_W;

    dr_path_t          path;
    logic [SR_W-1:0]   sr, sr_shift, sr_cap;
    logic [DW-1:0]     rdata_q;
    logic [KW-1:0]     ack_q;
    logic              busy_q, wait_q;

    always_comb begin
        unique case (op)
            OP_IDENT:  path = PATH_ID;
            OP_ACCESS: path = PATH_ACC;
            default:   path = PATH_BYP;
        endcase
    end

    always_comb begin
        sr_shift = sr >> 1;
        sr_cap   = '0;
        unique case (path)
            PATH_BYP: sr_shift[0]       = tdi;
            PATH_ID:  begin
                sr_shift[ID_W-1] = tdi;
                sr_cap[ID_W-1:0] = ID_VAL;
            end
            PATH_ACC: begin
                sr_shift[ACC_W-1] = tdi;
                sr_cap[ACC_W-1:0] = {rdata_q, busy_q ? KW'(ACK_WAIT) : ack_q};
            end
            default:  sr_shift = sr >> 1;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr        <= '0;
            rdata_q   <= '0;
            ack_q     <= KW'(ACK_OK);
            busy_q    <= 1'b0;
            wait_q    <= 1'b0;
            req_valid <= 1'b0;
            req_addr  <= '0;
            req_rnw   <= 1'b0;
            req_wdata <= '0;
        end else begin
            req_valid <= 1'b0;
            if (cap) begin
                sr <= sr_cap;
                if (path == PATH_ACC) wait_q <= busy_q;
            end else if (sh) begin
                sr <= sr_shift;
            end
            if (busy_q && rsp_valid) begin
                busy_q  <= 1'b0;
                rdata_q <= rsp_rdata;
                ack_q   <= rsp_ack;
            end
            if (up && path == PATH_ACC && !wait_q) begin
                req_valid <= 1'b1;
                req_rnw   <= sr[0];
                req_addr  <= sr[AW:1];
                req_wdata <= sr[ACC_W-1:KW];
                busy_q    <= 1'b1;
            end
        end
    end

    assign lsb = sr[0];

endmodule

// File: rtl/dbg_tap.sv
module dbg_tap
    import dbg_tap_pkg::*;
#(
    parameter int          DW     = 32,
    parameter int          AW     = 2,
    parameter int          KW     = 3,
    parameter logic [31:0] ID_VAL = 32'h0BA00477
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic          tms,
    input  logic          tdi,
    output logic          tdo,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic          req_rnw,
    output logic [DW-1:0] req_wdata,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_rdata,
    input  logic [KW-1:0] rsp_ack
);

    tap_state_t      state;
    logic            in_reset, cap_dr, sh_dr, up_dr, cap_ir, sh_ir, up_ir;
    logic [OP_W-1:0] ir_q;
    logic            ir_lsb, dr_lsb;

    dbg_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_dr(cap_dr), .sh_dr(sh_dr), .up_dr(up_dr),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .up_ir(up_ir)
    );

    dbg_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .cap(cap_ir), .sh(sh_ir), .up(up_ir), .op(ir_q), .lsb(ir_lsb)
    );

    dbg_tap_dr #(.DW(DW), .AW(AW), .KW(KW), .ID_VAL(ID_VAL)) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .op(ir_q),
        .cap(cap_dr), .sh(sh_dr), .up(up_dr),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack),
        .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_wdata(req_wdata), .lsb(dr_lsb)
    );

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)    tdo <= 1'b0;
        else if (sh_ir) tdo <= ir_lsb;
        else if (sh_dr) tdo <= dr_lsb;
        else            tdo <= 1'b0;
    end

endmodule

// File: rtl/dbg_tap_chk.sv
module dbg_tap_chk
    import dbg_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            req_valid,
    input tap_state_t      state,
    input logic [OP_W-1:0] ir_q
);

    assert_five_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_RESET));

    assert_reset_loads_ident_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir_q == OP_IDENT));

    assert_req_single_cycle_R7: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |=> !req_valid);

    assert_req_after_update_R7: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |-> ($past(state) == ST_UP_DR));

    assert_req_only_access_R7: assert property (@(posedge tck) disable iff (!trst_n)
        req_valid |-> (ir_q == OP_ACCESS));

endmodule

bind dbg_tap dbg_tap_chk u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .req_valid(req_valid),
    .state(state), .ir_q(ir_q)
);

// File: tb/sim_dbg_tap.sv
module sim_dbg_tap;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        req_valid;
    logic [1:0]  req_addr;
    logic        req_rnw;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic [2:0]  rsp_ack = 3'b010;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [31:0] ID = 32'h0BA00477;

    always #10 tck = ~tck;

    dbg_tap u0 (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_ack(rsp_ack)
    );

    // model of the outstanding-request state
    bit          m_busy  = 0;
    logic [31:0] m_rdata = '0;
    logic [2:0]  m_ack   = 3'b010;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        tms = m; tdi = d; o = tdo;
        @(posedge tck);
    endtask

    task automatic go(input logic m);
        logic o;
        tick(m, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] v, output logic [3:0] out);
        logic o;
        go(1); go(1); go(0); go(0);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, v[i], o);
            out[i] = o;
        end
        go(1); go(0);
    endtask

    task automatic scan_dr(input int len, input logic [34:0] din, output logic [34:0] dout);
        logic o;
        dout = '0;
        go(1); go(0); go(0);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], o);
            dout[i] = o;
        end
        go(1); go(0);
    endtask

    function automatic logic [34:0] exp_capture();
        return {m_rdata, m_busy ? 3'b001 : m_ack};
    endfunction

    function automatic logic [7:0] exp_bypass(input logic [7:0] din);
        return {din[6:0], 1'b0};
    endfunction

    task automatic respond(input logic [31:0] d, input logic [2:0] k);
        @(negedge tck); #1;
        rsp_valid = 1'b1; rsp_rdata = d; rsp_ack = k;
        @(negedge tck); #1;
        rsp_valid = 1'b0;
        if (m_busy) begin
            m_busy = 0; m_rdata = d; m_ack = k;
        end
    endtask

    task automatic access(input logic [34:0] din);
        logic [34:0] dout;
        bit          issue;
        issue = !m_busy;
        scan_dr(35, din, dout);
        check("R8/R9 access capture", 64'(dout), 64'(exp_capture()));
        #2;
        if (issue) begin
            check("R7 req_valid", 64'(req_valid), 64'd1);
            check("R7 request fields", {req_wdata, req_addr, req_rnw}, 64'(din));
            m_busy = 1;
        end else begin
            check("R9 request dropped", 64'(req_valid), 64'd0);
        end
    endtask

    initial begin
        logic [3:0]  iro;
        logic [34:0] dout;
        logic        o, o2;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge tck);
        #2;
        check("R1 reset tdo", 64'(tdo), 64'd0);
        check("R7 reset req_valid", 64'(req_valid), 64'd0);
        @(negedge tck); #1 trst_n = 1'b1;
        go(0);

        // R4: identification after reset
        scan_dr(32, 35'h0, dout);
        check("R4 ident value", 64'(dout[31:0]), 64'(ID));

        // R3: capture pattern, then bypass
        scan_ir(4'b1111, iro);
        check("R3 IR capture", 64'(iro), 64'h1);
        scan_dr(8, 35'h0000000A5, dout);
        check("R5 bypass delay", 64'(dout[7:0]), 64'(exp_bypass(8'hA5)));

        // R10: TDO does not move on the rising edge
        go(1); go(0); go(0);
        tdi = 1'b1;
        @(negedge tck); #1; tms = 1'b0; tdi = 1'b1;
        @(posedge tck); #1 o = tdo;
        @(negedge tck); #1 o2 = tdo;
        check("R10 rise holds tdo", 64'(o), 64'd0);
        check("R10 fall updates tdo", 64'(o2), 64'd1);
        go(1); go(1); go(0);

        // R1: five TMS-high edges force reset and reload IDCODE
        repeat (5) go(1);
        go(0);
        scan_dr(32, 35'h0, dout);
        check("R1 tms reset ident", 64'(dout[31:0]), 64'(ID));

        // R6: unused code as bypass
        scan_ir(4'b0101, iro);
        scan_dr(8, 35'h00000003C, dout);
        check("R6 unused code bypass", 64'(dout[7:0]), 64'(exp_bypass(8'h3C)));

        // R2: pause and exit2 loop back into shift on ident
        scan_ir(4'b1110, iro);
        go(1); go(0); go(0);
        dout = '0;
        for (int i = 0; i < 16; i++) begin tick(i == 15, 1'b0, o); dout[i] = o; end
        go(0); go(0); go(1); go(0);
        for (int i = 16; i < 32; i++) begin tick(i == 31, 1'b0, o); dout[i] = o; end
        go(1); go(0);
        check("R2 pause/exit2 ident", 64'(dout[31:0]), 64'(ID));

        // R8/R7/R9: access register, directed
        scan_ir(4'b1010, iro);
        access({32'hDEADBEEF, 2'b10, 1'b1});
        access({32'h12345678, 2'b01, 1'b0});
        respond(32'hCAFE0001, 3'b010);
        respond(32'h0BAD0BAD, 3'b111);
        access({32'h00000000, 2'b11, 1'b1});
        respond(32'h55AA55AA, 3'b001);

        // random traffic
        for (int it = 0; it < 40; it++) begin
            access({$urandom(), 3'($urandom())});
            if ($urandom_range(0, 9) < 6)
                respond($urandom(), ($urandom_range(0, 1) != 0) ? 3'b010 : 3'b001);
        end

        // R1: TRST returns to ident and clears held response
        @(negedge tck); #1 trst_n = 1'b0;
        @(negedge tck); #1 trst_n = 1'b1;
        m_busy = 0; m_rdata = '0; m_ack = 3'b010;
        go(0);
        scan_dr(32, 35'h0, dout);
        check("R1 trst ident", 64'(dout[31:0]), 64'(ID));
        scan_ir(4'b1010, iro);
        access({32'hA5A5A5A5, 2'b00, 1'b0});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule